// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block counts down a programmable 8-bit value and raises an interrupt each time the count steps from one to zero. A source select picks the rate at which the count moves. The choices are 4096 Hz, 64 Hz, one step per second, and one step per minute. All of these rates are derived inside the block from a single 8192 Hz enable strobe, `base_tick`, through a chain of dividers. The time between interrupts is therefore the preset multiplied by the period of the selected source.

The timer flag `flag` records each event and holds its value until software clears it. The interrupt request `irq_n` is active low and models an open-drain pin: 1 means released, 0 means pulled low. It works in one of two modes:

- **Level mode:** `irq_n` follows the flag and stays low until the flag is cleared.
- **Repeated mode:** `irq_n` gives a short pulse that ends by itself, and the counter keeps reloading.

In both modes the count reloads from the preset after each event. Counting continues for as long as the enable stays high.

Top module: `cycle_timer_irq`

## Requirements
- R1: After reset `flag` is 0 and `irq_n` is 1.
- R2: `src_sel` chooses the step rate. 00 is 4096 Hz (2 base ticks), 01 is 64 Hz, 10 is 1 Hz and 11 is one step per minute. With `base_tick` high every cycle and `en` first sampled high at edge E0, the first event shows after edge E(preset×D−1), where D is the base-tick length of the selected step.
- R3: An event happens only when the count moves from 01h to 00h. A preset of 00h never produces an event.
- R4: An event sets `flag`. It then stays 1, even with `en` low, until `flag_clr` is sampled high.
- R5: With `irq_en` = 0, `irq_n` stays 1 whatever `flag` does.
- R6: In level mode (`repeat_mode` = 0) with `irq_en` = 1, `irq_n` is 0 while `flag` is 1. It returns to 1 on the edge that clears the flag.
- R7: In repeated mode the count reloads from the preset on each event, so successive events are preset×D base ticks apart.
- R8: In repeated mode each event drives `irq_n` low for a fixed time, independent of `flag`. The time is 1 base tick when `src_sel` = 00 and 2 base ticks for the other sources.
- R9: While `en` is 0 the count and the dividers are frozen or cleared. A rise of `en` loads the preset and restarts timing from zero.
- R10: In level mode counting goes on after an event, and the next event sets the flag again one full interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | One-cycle strobe at 8192 Hz |
| en | input | 1 | Timer run enable; a rise loads the preset |
| src_sel | input | 2 | Step-rate select |
| preset | input | 8 | Reload value of the count |
| repeat_mode | input | 1 | 1 = auto-recovering pulse, 0 = level interrupt |
| irq_en | input | 1 | Lets events reach `irq_n` |
| flag_clr | input | 1 | Clears `flag` when sampled high |
| flag | output | 1 | Event flag |
| irq_n | output | 1 | Interrupt request, 0 = pulled low |

## Verification
The slow sources are the hard part to reach from the ports. At the default divider ratios a single step per minute takes about half a million base ticks. The bench therefore overrides the divider parameters with small values, which keeps every source, including a full-scale preset of 255, within a few hundred cycles.

The bench also holds `base_tick` high every cycle, so every interval and every recovery pulse can be predicted to the exact edge. The stop-and-restart case is reached by dropping `en` partway through a count and checking that the next run starts timing from zero.

// File: rtl/cycle_timer_irq.sv
module cycle_timer_irq #(
  parameter int SUB64 = 64,
  parameter int SUB1  = 64,
  parameter int SUB60 = 60,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic          en,
  input  logic [1:0]    src_sel,
  input  logic [CW-1:0] preset,
  input  logic          repeat_mode,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          flag,
  output logic          irq_n
);
  localparam int W64 = SUB64 > 1 ? $clog2(SUB64) : 1;
  localparam int W1  = SUB1  > 1 ? $clog2(SUB1)  : 1;
  localparam int WM  = SUB60 > 1 ? $clog2(SUB60) : 1;
  localparam logic [W64-1:0] L64 = W64'(SUB64 - 1);
  localparam logic [W1-1:0]  L1  = W1'(SUB1 - 1);
  localparam logic [WM-1:0]  LM  = WM'(SUB60 - 1);

  logic           ph;
  logic [W64-1:0] c64;
  logic [W1-1:0]  c1;
  logic [WM-1:0]  cm;
  logic           en_q;
  logic [CW-1:0]  cnt_q;
  logic [1:0]     rec;

  wire tk4096 = en & base_tick & ph;
  wire tk64   = tk4096 & (c64 == L64);
  wire tk1    = tk64 & (c1 == L1);
  wire tkm    = tk1 & (cm == LM);
  wire start  = en & ~en_q;

  logic src_tick;
  always_comb begin
    case (src_sel)
      2'b00:   src_tick = tk4096;
      2'b01:   src_tick = tk64;
      2'b10:   src_tick = tk1;
      default: src_tick = tkm;
    endcase
  end

  wire hit = en & ~start & src_tick & (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= 1'b0;
      c64 <= '0;
      c1  <= '0;
      cm  <= '0;
    end else if (!en) begin
      ph  <= 1'b0;
      c64 <= '0;
      c1  <= '0;
      cm  <= '0;
    end else begin
      if (base_tick) ph <= ~ph;
      if (tk4096) c64 <= (c64 == L64) ? '0 : c64 + 1'b1;
      if (tk64)   c1  <= (c1 == L1)   ? '0 : c1 + 1'b1;
      if (tk1)    cm  <= (cm == LM)   ? '0 : cm + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en;
      if (start)
        cnt_q <= preset;
      else if (en && src_tick) begin
        if (cnt_q == CW'(1))
          cnt_q <= preset;
        else if (cnt_q != '0)
          cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rec <= 2'd0;
    else if (!en)
      rec <= 2'd0;
    else if (hit && repeat_mode)
      rec <= (src_sel == 2'b00) ? 2'd1 : 2'd2;
    else if (base_tick && rec != 2'd0)
      rec <= rec - 2'd1;
  end

  assign irq_n = ~(irq_en & (repeat_mode ? (rec != 2'd0) : flag));
endmodule

// File: rtl/timer_irq_chk.sv
module timer_irq_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [CW-1:0] preset,
  input logic          flag,
  input logic          flag_clr,
  input logic [CW-1:0] cnt,
  input logic          stick
);
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);
  p_fire_from_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(cnt) == CW'(1));
  p_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && cnt == '0 && preset == '0 && !flag |=> !flag);
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && stick && cnt == CW'(1) |=> cnt == $past(preset));
endmodule

bind cycle_timer_irq timer_irq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .preset(preset), .flag(flag),
  .flag_clr(flag_clr), .cnt(cnt_q), .stick(src_tick));

// File: tb/cycle_timer_irq_test.sv
module cycle_timer_irq_test;
  logic clk = 1'b0, rst_n = 1'b0, base_tick = 1'b1, en = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] preset = 8'd0;
  logic repeat_mode = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic flag, irq_n;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cycle_timer_irq #(.SUB64(2), .SUB1(3), .SUB60(2)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .en(en),
    .src_sel(src_sel), .preset(preset), .repeat_mode(repeat_mode),
    .irq_en(irq_en), .flag_clr(flag_clr), .flag(flag), .irq_n(irq_n));

  // {src[1:0], preset[7:0], repeat, irq_en, latency[15:0]}; D = 2,4,12,24
  localparam logic [27:0] VEC [8] = '{
    {2'd0, 8'd5,   1'b0, 1'b1, 16'd10},
    {2'd1, 8'd3,   1'b0, 1'b1, 16'd12},
    {2'd2, 8'd2,   1'b1, 1'b1, 16'd24},
    {2'd3, 8'd1,   1'b1, 1'b1, 16'd24},
    {2'd0, 8'd1,   1'b1, 1'b1, 16'd2},
    {2'd0, 8'd255, 1'b0, 1'b1, 16'd510},
    {2'd1, 8'd4,   1'b1, 1'b1, 16'd16},
    {2'd0, 8'd3,   1'b0, 1'b0, 16'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wait_flag(output int c);
    c = 0;
    while (!flag && c < 5000) begin
      step(1);
      c++;
    end
  endtask

  task automatic restart();
    en = 1'b0; flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c, w, d;
    step(2);
    chk("R1 flag", flag, 0);
    chk("R1 irq_n", irq_n, 1);
    rst_n = 1'b1;
    step(1);
    chk("R1 flag after release", flag, 0);

    for (int v = 0; v < 8; v++) begin
      restart();
      src_sel = VEC[v][27:26]; preset = VEC[v][25:18];
      repeat_mode = VEC[v][17]; irq_en = VEC[v][16];
      en = 1'b1;
      wait_flag(c);
      chk($sformatf("R2 latency vec%0d", v), c, int'(VEC[v][15:0]));
      if (!irq_en) begin
        chk("R5 irq masked", irq_n, 1);
        step(3);
        chk("R5 irq masked later", irq_n, 1);
      end else if (repeat_mode) begin
        chk("R8 pulse starts", irq_n, 0);
        w = 0;
        while (!irq_n && w < 10) begin step(1); w++; end
        chk($sformatf("R8 pulse width vec%0d", v), w, (src_sel == 2'd0) ? 1 : 2);
        chk("R8 flag stays set", flag, 1);
        d = w;
        while (irq_n && d < 5000) begin step(1); d++; end
        chk($sformatf("R7 repeat interval vec%0d", v), d, int'(VEC[v][15:0]));
      end else begin
        chk("R6 level low", irq_n, 0);
        step(5);
        chk("R6 level held", irq_n, 0);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R6 released on clear", irq_n, 1);
        chk("R4 flag cleared", flag, 0);
      end
    end

    restart();
    src_sel = 2'd0; preset = 8'd0; repeat_mode = 1'b0; irq_en = 1'b1; en = 1'b1;
    step(600);
    chk("R3 preset zero no event", flag, 0);
    chk("R3 preset zero irq idle", irq_n, 1);

    restart();
    preset = 8'd4; en = 1'b1;
    step(5);
    en = 1'b0;
    step(50);
    chk("R9 stopped no flag", flag, 0);
    en = 1'b1;
    wait_flag(c);
    chk("R9 fresh start latency", c, 8);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk("R10 flag cleared", flag, 0);
    wait_flag(c);
    chk("R10 next event interval", c, 7);
    chk("R10 irq low again", irq_n, 0);
    en = 1'b0;
    step(20);
    chk("R4 flag holds with en low", flag, 1);
    chk("R6 irq follows held flag", irq_n, 0);

    restart();
    src_sel = 2'd1; preset = 8'd2; repeat_mode = 1'b1; irq_en = 1'b0; en = 1'b1;
    wait_flag(c);
    chk("R2 latency src01 preset2", c, 8);
    chk("R5 repeat masked", irq_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule